// File: doc/BRIEF.md
# Debug Local Bus Arbiter

This block lets a debug unit borrow the processor's local bus for a single memory transfer while the core keeps executing. When the debug side raises a memory-access request, the arbiter stalls the core's instruction fetch. It waits until the core's in-flight bus cycle has finished. It then grants the bus to the debug side for exactly one transfer. After that transfer it hands the bus back to the core and drops the stall.

A request that arrives while the core is reclaiming the bus is remembered and served later. Before it is served, the core is given a guaranteed stretch of stall-free cycles, so a stream of debug requests cannot starve the core. Debug commands that target the core's own registers are screened separately. While the core runs they are refused with a one-cycle error pulse and cause no bus activity. While the core is halted they are acknowledged.

The bus protocol, the memory and the serial command decoder are outside the block. They are represented by level and pulse handshake signals.

Top module: `dbg_bus_arb`

## Requirements
- R1: After reset, fetch_stall, dbg_grant, reg_err and reg_ack are low and core_bus_en is high.
- R2: A one-cycle pulse on dbg_req that is sampled while the arbiter is idle and its hold window has ended raises fetch_stall from the next cycle on. dbg_grant stays low in that cycle.
- R3: dbg_grant rises only on the clock edge after a stalled cycle in which core_bus_busy was sampled low. While core_bus_busy stays high, fetch_stall remains high and dbg_grant remains low.
- R4: dbg_grant and core_bus_en are never high in the same cycle, and core_bus_en is low only while dbg_grant is high.
- R5: dbg_grant stays high until dbg_xfer_done is sampled high. In the cycle after that, dbg_grant and fetch_stall are both low.
- R6: After each debug transfer, fetch_stall stays low for at least HOLD_CYCLES+1 cycles. The default HOLD_CYCLES is 1, which gives two cycles. A dbg_req pulse that arrives in that window is kept and raises fetch_stall in the first cycle after the window ends.
- R7: A dbg_reg_cmd pulse sampled while core_halted is low makes reg_err high for exactly the next cycle. reg_ack stays low, and fetch_stall and dbg_grant are not raised.
- R8: A dbg_reg_cmd pulse sampled while core_halted is high makes reg_ack high for exactly the next cycle, and reg_err stays low.
- R9: dbg_xfer_done sampled while the debug side does not own the bus has no effect: fetch_stall, dbg_grant and core_bus_en keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_req | input | 1 | One-cycle pulse: debug memory-access command wants the bus |
| dbg_xfer_done | input | 1 | Debug bus cycle has completed |
| dbg_reg_cmd | input | 1 | One-cycle pulse: debug command targeting core registers |
| core_halted | input | 1 | High while the core is halted, low while it runs |
| core_bus_busy | input | 1 | Core bus cycle in progress |
| fetch_stall | output | 1 | Stall request to the core's instruction fetch |
| dbg_grant | output | 1 | Bus owned by the debug unit |
| core_bus_en | output | 1 | Core may drive the bus |
| reg_err | output | 1 | Register command refused (one cycle) |
| reg_ack | output | 1 | Register command accepted (one cycle) |

## Verification
Every output is decoded from a register, so each result is due one clock edge after the input that causes it is sampled. fetch_stall follows an accepted request after one edge. dbg_grant follows the first sampled drain after one edge. The release follows dbg_xfer_done after one edge, and reg_err or reg_ack follows dbg_reg_cmd after one edge. The hold window adds HOLD_CYCLES+1 stall-free cycles before a queued request takes effect. The bench drives and samples one time unit after each rising edge and checks each output at exactly the edge count listed here, cycle by cycle across the busy, hold and release windows.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE       = 2'd0,
    ARB_STALL_WAIT = 2'd1,
    ARB_DEBUG_OWN  = 2'd2,
    ARB_RECLAIM    = 2'd3
  } arb_state_e;

  // fetch stall is requested while waiting for the drain and while owning
  function automatic logic stall_of(arb_state_e st);
    return (st == ARB_STALL_WAIT) || (st == ARB_DEBUG_OWN);
  endfunction

  function automatic logic grant_of(arb_state_e st);
    return st == ARB_DEBUG_OWN;
  endfunction

  // the core keeps its bus enable unless the debug side owns it
  function automatic logic core_en_of(arb_state_e st);
    return st != ARB_DEBUG_OWN;
  endfunction

  // width able to hold the value n (at least one bit)
  function automatic int cnt_width(int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/dbg_req_hold.sv
module dbg_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_req,
  input  logic accept,
  output logic req_seen
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (accept) pend_q <= 1'b0;
    else if (dbg_req) pend_q <= 1'b1;
  end

  assign req_seen = pend_q | dbg_req;
endmodule

// File: rtl/dbg_arb_hold.sv
module dbg_arb_hold #(
  parameter int HOLD_CYCLES = 1,
  localparam int HOLD_W = dbg_arb_pkg::cnt_width(HOLD_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic open_o
);
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (load)                        cnt_q <= HOLD_W'(HOLD_CYCLES);
    else if (tick && (cnt_q != '0))       cnt_q <= cnt_q - 1'b1;
  end

  assign open_o = (cnt_q == '0);
endmodule

// File: rtl/dbg_arb_fsm.sv
module dbg_arb_fsm
  import dbg_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_seen,
  input  logic       hold_open,
  input  logic       core_bus_busy,
  input  logic       dbg_xfer_done,
  output arb_state_e state_o,
  output logic       ev_accept,
  output logic       ev_drain,
  output logic       ev_release
);
  arb_state_e st_q, st_d;

  assign ev_accept  = (st_q == ARB_IDLE) && req_seen && hold_open;
  assign ev_drain   = (st_q == ARB_STALL_WAIT) && !core_bus_busy;
  assign ev_release = (st_q == ARB_DEBUG_OWN) && dbg_xfer_done;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ARB_IDLE:       if (ev_accept)  st_d = ARB_STALL_WAIT;
      ARB_STALL_WAIT: if (ev_drain)   st_d = ARB_DEBUG_OWN;
      ARB_DEBUG_OWN:  if (ev_release) st_d = ARB_RECLAIM;
      ARB_RECLAIM:                    st_d = ARB_IDLE;
      default:                        st_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARB_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/dbg_reg_guard.sv
module dbg_reg_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_reg_cmd,
  input  logic core_halted,
  output logic reg_err,
  output logic reg_ack
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_err <= 1'b0;
      reg_ack <= 1'b0;
    end else begin
      reg_err <= dbg_reg_cmd && !core_halted;
      reg_ack <= dbg_reg_cmd &&  core_halted;
    end
  end
endmodule

// File: rtl/dbg_bus_arb.sv
module dbg_bus_arb
  import dbg_arb_pkg::*;
#(
  parameter int HOLD_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_req,
  input  logic dbg_xfer_done,
  input  logic dbg_reg_cmd,
  input  logic core_halted,
  input  logic core_bus_busy,
  output logic fetch_stall,
  output logic dbg_grant,
  output logic core_bus_en,
  output logic reg_err,
  output logic reg_ack
);
  arb_state_e state;
  logic req_seen, hold_open;
  logic ev_accept, ev_drain, ev_release;
  logic ev_reclaim;

  assign ev_reclaim = (state == ARB_RECLAIM);

  dbg_req_hold u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbg_req  (dbg_req),
    .accept   (ev_accept),
    .req_seen (req_seen)
  );

  dbg_arb_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ev_reclaim),
    .tick   (state == ARB_IDLE),
    .open_o (hold_open)
  );

  dbg_arb_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_seen      (req_seen),
    .hold_open     (hold_open),
    .core_bus_busy (core_bus_busy),
    .dbg_xfer_done (dbg_xfer_done),
    .state_o       (state),
    .ev_accept     (ev_accept),
    .ev_drain      (ev_drain),
    .ev_release    (ev_release)
  );

  dbg_reg_guard u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .dbg_reg_cmd (dbg_reg_cmd),
    .core_halted (core_halted),
    .reg_err     (reg_err),
    .reg_ack     (reg_ack)
  );

  assign fetch_stall = stall_of(state);
  assign dbg_grant   = grant_of(state);
  assign core_bus_en = core_en_of(state);
endmodule

// File: rtl/dbg_bus_arb_chk.sv
module dbg_bus_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic dbg_reg_cmd,
  input logic core_halted,
  input logic core_bus_busy,
  input logic dbg_xfer_done,
  input logic fetch_stall,
  input logic dbg_grant,
  input logic core_bus_en,
  input logic reg_err,
  input logic reg_ack,
  input logic ev_accept,
  input logic ev_drain,
  input logic ev_release
);
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_grant && core_bus_en));

  a_r4_en_only_off_for_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !core_bus_en |-> dbg_grant);

  a_r2_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> fetch_stall && !dbg_grant);

  a_r3_grant_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_grant) |-> $past(fetch_stall) && !$past(core_bus_busy));

  a_r3_drain_grants: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drain |=> dbg_grant);

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> !dbg_grant && !fetch_stall);

  a_r5_grant_holds: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_grant && !dbg_xfer_done |=> dbg_grant);

  a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbg_grant) |=> !fetch_stall);

  a_r7_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_reg_cmd && !core_halted |=> reg_err && !reg_ack);

  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_reg_cmd && core_halted |=> reg_ack && !reg_err);
endmodule

bind dbg_bus_arb dbg_bus_arb_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dbg_reg_cmd   (dbg_reg_cmd),
  .core_halted   (core_halted),
  .core_bus_busy (core_bus_busy),
  .dbg_xfer_done (dbg_xfer_done),
  .fetch_stall   (fetch_stall),
  .dbg_grant     (dbg_grant),
  .core_bus_en   (core_bus_en),
  .reg_err       (reg_err),
  .reg_ack       (reg_ack),
  .ev_accept     (ev_accept),
  .ev_drain      (ev_drain),
  .ev_release    (ev_release)
);

// File: tb/test_dbg_bus_arb.sv
`timescale 1ns/1ps
module test_dbg_bus_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_req = 1'b0, dbg_xfer_done = 1'b0, dbg_reg_cmd = 1'b0;
  logic core_halted = 1'b0, core_bus_busy = 1'b0;
  logic fetch_stall, dbg_grant, core_bus_en, reg_err, reg_ack;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  dbg_bus_arb i_dbg_bus_arb (
    .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .dbg_xfer_done(dbg_xfer_done),
    .dbg_reg_cmd(dbg_reg_cmd), .core_halted(core_halted), .core_bus_busy(core_bus_busy),
    .fetch_stall(fetch_stall), .dbg_grant(dbg_grant), .core_bus_en(core_bus_en),
    .reg_err(reg_err), .reg_ack(reg_ack)
  );

  // outputs packed as {stall, grant, en, err, ack}
  function automatic logic [4:0] outs(logic s, logic g, logic e, logic r, logic a);
    return {s, g, e, r, a};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [4:0] exp);
    logic [4:0] act;
    act = outs(fetch_stall, dbg_grant, core_bus_en, reg_err, reg_ack);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (stall,grant,en,err,ack)", req, act, exp);
    end
  endtask

  localparam logic [4:0] O_IDLE  = 5'b00100;
  localparam logic [4:0] O_STALL = 5'b10100;
  localparam logic [4:0] O_OWN   = 5'b11000;

  task automatic t_reset();
    check("R1", O_IDLE);
  endtask

  // request accepted, optional busy cycles, then ownership and release
  task automatic run_xfer(string tag, int busy_cycles, int own_cycles);
    core_bus_busy = (busy_cycles > 0);
    dbg_req = 1'b1;
    step();
    dbg_req = 1'b0;
    check({tag, " R2"}, O_STALL);
    for (int i = 1; i < busy_cycles; i++) begin
      step();
      check({tag, " R3 busy"}, O_STALL);
    end
    core_bus_busy = 1'b0;
    step();
    check({tag, " R3/R4 grant"}, O_OWN);
    for (int i = 0; i < own_cycles; i++) begin
      step();
      check({tag, " R5 hold"}, O_OWN);
    end
    dbg_xfer_done = 1'b1;
    step();
    dbg_xfer_done = 1'b0;
    check({tag, " R5 release"}, O_IDLE);
  endtask

  task automatic t_basic();
    run_xfer("basic", 0, 2);
    step(); step();
  endtask

  task automatic t_busy();
    run_xfer("busy", 4, 0);
    step(); step();
  endtask

  task automatic t_starve();
    run_xfer("starve", 0, 0);
    // now in the reclaim cycle: pulse a new request
    dbg_req = 1'b1;
    step();
    dbg_req = 1'b0;
    check("R6 held 1", O_IDLE);
    step();
    check("R6 held 2", O_IDLE);
    step();
    check("R6 served", O_STALL);
    step();
    check("R6 grant", O_OWN);
    dbg_xfer_done = 1'b1;
    step();
    dbg_xfer_done = 1'b0;
    check("R6 release", O_IDLE);
    step(); step();
  endtask

  task automatic t_done_ignored();
    dbg_xfer_done = 1'b1;
    step();
    dbg_xfer_done = 1'b0;
    check("R9 idle", O_IDLE);
    dbg_req = 1'b1;
    core_bus_busy = 1'b1;
    step();
    dbg_req = 1'b0;
    dbg_xfer_done = 1'b1;
    step();
    dbg_xfer_done = 1'b0;
    check("R9 stalled", O_STALL);
    core_bus_busy = 1'b0;
    step();
    check("R9 grant", O_OWN);
    dbg_xfer_done = 1'b1;
    step();
    dbg_xfer_done = 1'b0;
    step(); step();
  endtask

  task automatic t_reg_run();
    core_halted = 1'b0;
    dbg_reg_cmd = 1'b1;
    step();
    dbg_reg_cmd = 1'b0;
    check("R7 err", 5'b00110);
    step();
    check("R7 one cycle", O_IDLE);
  endtask

  task automatic t_reg_halt();
    core_halted = 1'b1;
    dbg_reg_cmd = 1'b1;
    step();
    dbg_reg_cmd = 1'b0;
    check("R8 ack", 5'b00101);
    step();
    check("R8 one cycle", O_IDLE);
    core_halted = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #1;
    t_reset();
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_busy();
    t_starve();
    t_done_ignored();
    t_reg_run();
    t_reg_halt();
    finish_run();
  end
endmodule